// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It drives a two-bit phase-select code to an external analog front end and watches that front end's single comparator output. Each conversion runs four phases in a fixed cycle: offset nulling (auto zero), fixed-length integration of the input, timed deintegration against a reference, and an integrator-discharge phase. The duration of the deintegration phase is the conversion result.

During integration the block takes the input polarity from the comparator. During deintegration it counts clock cycles until the comparator falls. It then publishes an unsigned magnitude, a sign bit and an over-range flag, together with a one-cycle valid strobe. Phase lengths and limits are parameters. A conversion starts on a start pulse, or repeats without a pulse while a continuous-mode input is held high. A discharge phase that never completes is cut short by a timeout, which leaves a sticky error flag set.

Top module: `dslope_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `phase_ab_o` is 2'b01 (auto zero), and `result_valid_o`, `result_mag_o`, `result_sign_o`, `result_ovr_o` and `zero_err_o` are all 0.
- R2: The phase code on `phase_ab_o` (bit 1 = A, bit 0 = B) is 01 for auto zero, 10 for integrate, 11 for deintegrate and 00 for integrator zero. It only ever steps 01→10→11→00→01.
- R3: Auto zero lasts at least `AZ_CYCLES` cycles. After that the block stays in auto zero until a start request or continuous mode is present. Comparator activity during auto zero has no effect.
- R4: Integration lasts exactly `INT_CYCLES` cycles, and deintegration (11) follows on the very next cycle.
- R5: `result_sign_o` is taken from the synchronized comparator in the last integration cycle. 1 means negative (comparator low) and 0 means positive (comparator high).
- R6: The comparator passes through two flops. If `cmp_i` is first sampled low at the clock edge that closes deintegration cycle j (the first cycle is 0), then `result_mag_o` is j. The two cycles of synchronizer latency are removed, and a fall seen in the first two cycles gives 0.
- R7: If no falling edge is seen by deintegration cycle `DEINT_MAX`+1, then `result_ovr_o` is 1, `result_mag_o` saturates to `DEINT_MAX`, and the block moves to integrator zero. Otherwise `result_ovr_o` is 0.
- R8: Integrator zero (00) is held until the synchronized comparator is high. Auto zero follows on the next cycle.
- R9: If the comparator has not returned high after `ZERO_TIMEOUT` cycles of integrator zero, the block enters auto zero anyway and sets `zero_err_o`. This flag stays set until reset.
- R10: `result_valid_o` pulses for exactly one cycle, in the first integrator-zero cycle of each conversion. The result outputs change only together with that pulse.
- R11: A `start_i` pulse seen outside auto zero is remembered and starts the next conversion once auto zero has lasted `AZ_CYCLES`. While `continuous_i` is high, conversions repeat with no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (pulse) |
| continuous_i | input | 1 | Repeat conversions while high |
| cmp_i | input | 1 | Asynchronous comparator output of the front end |
| phase_ab_o | output | 2 | Phase select {A,B} to the front end |
| result_mag_o | output | MAG_W | Deintegration count, latency-corrected |
| result_sign_o | output | 1 | 1 = negative input |
| result_ovr_o | output | 1 | Over-range: no zero crossing in time |
| result_valid_o | output | 1 | One-cycle strobe with each new result |
| zero_err_o | output | 1 | Sticky integrator-zero timeout flag |

## Verification
On every cycle, the assertions check that the phase code steps only in the legal order, that integration ends exactly at its length and auto zero never ends early, that the valid strobe lasts one cycle with the result held stable between strobes, that over-range always comes with a saturated magnitude, and that the error flag is sticky. Only the bench scenarios show that the magnitude equals the cycle index of the comparator fall after latency removal, and that the sign follows the polarity held during integration. The same holds for the integrator-zero timeout length, for a start request queued during a conversion, and for continuous mode restarting on its own and stopping once released.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    // Phase codes double as the {A,B} pins driven to the front end.
    typedef enum logic [1:0] {
        PH_IZ    = 2'b00,
        PH_AZ    = 2'b01,
        PH_INT   = 2'b10,
        PH_DEINT = 2'b11
    } phase_e;

    // Flags published with each result.
    typedef struct packed {
        logic sign;
        logic ovr;
    } res_flags_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Legal successor of each phase.
    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_AZ:    return PH_INT;
            PH_INT:   return PH_DEINT;
            PH_DEINT: return PH_IZ;
            default:  return PH_AZ;
        endcase
    endfunction

endpackage

// File: rtl/dslope_cmp_sync.sv
module dslope_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_i,
    output logic lvl_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], cmp_i};
    end

    assign lvl_o  = sh[STAGES-1];
    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int AZ_CYCLES    = 123093,
    parameter int INT_CYCLES   = 123093,
    parameter int DEINT_MAX    = 246186,
    parameter int ZERO_TIMEOUT = 3686,
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = 18,
    parameter int MAG_W        = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             continuous_i,
    input  logic             cmp_lvl_i,
    input  logic             cmp_fall_i,
    output phase_e           phase_o,
    output logic             sign_load_o,
    output logic             sign_val_o,
    output logic             cap_o,
    output logic [MAG_W-1:0] cap_mag_o,
    output logic             cap_ovr_o,
    output logic             zero_err_o
);
    localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'(DEINT_MAX + SYNC_STAGES - 1);
    localparam logic [CNT_W-1:0] IZ_LAST    = CNT_W'(ZERO_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] SYNC_C     = CNT_W'(SYNC_STAGES);
    localparam logic [MAG_W-1:0] MAG_SAT    = MAG_W'(DEINT_MAX);

    phase_e           state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             pend;
    logic             err_set;
    logic             go;

    assign go = pend | start_i | continuous_i;

    always_comb begin
        nxt         = state;
        sign_load_o = 1'b0;
        cap_o       = 1'b0;
        cap_mag_o   = '0;
        cap_ovr_o   = 1'b0;
        err_set     = 1'b0;
        case (state)
            PH_AZ: begin
                // comparator deliberately not consulted here
                if (cnt >= AZ_LAST && go) nxt = PH_INT;
            end
            PH_INT: begin
                if (cnt == INT_LAST) begin
                    sign_load_o = 1'b1;
                    nxt         = PH_DEINT;
                end
            end
            PH_DEINT: begin
                if (cmp_fall_i) begin
                    cap_o     = 1'b1;
                    cap_mag_o = (cnt >= SYNC_C) ? MAG_W'(cnt - SYNC_C) : '0;
                    nxt       = PH_IZ;
                end else if (cnt == DEINT_LAST) begin
                    cap_o     = 1'b1;
                    cap_mag_o = MAG_SAT;
                    cap_ovr_o = 1'b1;
                    nxt       = PH_IZ;
                end
            end
            default: begin
                if (cmp_lvl_i) begin
                    nxt = PH_AZ;
                end else if (cnt == IZ_LAST) begin
                    err_set = 1'b1;
                    nxt     = PH_AZ;
                end
            end
        endcase
    end

    assign sign_val_o = ~cmp_lvl_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_AZ;
            cnt        <= '0;
            pend       <= 1'b0;
            zero_err_o <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= '0;
            else if (!(state == PH_AZ && cnt >= AZ_LAST))
                cnt <= cnt + 1'b1;
            if (state == PH_AZ && nxt == PH_INT) pend <= 1'b0;
            else if (start_i)                    pend <= 1'b1;
            if (err_set) zero_err_o <= 1'b1;
        end
    end

    assign phase_o = state;

    AST_AB_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> (state == next_phase($past(state)))); // R2
    AST_INT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (state == PH_DEINT && $past(state) == PH_INT) |-> ($past(cnt) == INT_LAST)); // R4
    AST_AZ_MINIMUM: assert property (@(posedge clk) disable iff (rst)
        (state == PH_INT && $past(state) == PH_AZ) |-> ($past(cnt) == AZ_LAST)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        zero_err_o |=> zero_err_o); // R9
endmodule

// File: rtl/dslope_result.sv
module dslope_result
    import dslope_pkg::*;
#(
    parameter int MAG_W     = 18,
    parameter int DEINT_MAX = 246186
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sign_load_i,
    input  logic             sign_val_i,
    input  logic             cap_i,
    input  logic [MAG_W-1:0] cap_mag_i,
    input  logic             cap_ovr_i,
    output logic [MAG_W-1:0] mag_o,
    output res_flags_t       flags_o,
    output logic             valid_o
);
    logic sign_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_hold <= 1'b0;
            mag_o     <= '0;
            flags_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= cap_i;
            if (sign_load_i) sign_hold <= sign_val_i;
            if (cap_i) begin
                mag_o        <= cap_mag_i;
                flags_o.sign <= sign_hold;
                flags_o.ovr  <= cap_ovr_i;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R10
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(mag_o) && $stable(flags_o))); // R10
    AST_OVR_SATURATED: assert property (@(posedge clk) disable iff (rst)
        flags_o.ovr |-> (mag_o == MAG_W'(DEINT_MAX))); // R7
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int AZ_CYCLES    = 123093,
    parameter int INT_CYCLES   = 123093,
    parameter int DEINT_MAX    = 246186,
    parameter int ZERO_TIMEOUT = 3686,
    parameter int SYNC_STAGES  = 2,
    parameter int MAG_W        = $clog2(DEINT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             continuous_i,
    input  logic             cmp_i,
    output logic [1:0]       phase_ab_o,
    output logic [MAG_W-1:0] result_mag_o,
    output logic             result_sign_o,
    output logic             result_ovr_o,
    output logic             result_valid_o,
    output logic             zero_err_o
);
    localparam int CNT_TOP = imax(imax(AZ_CYCLES, INT_CYCLES),
                                  imax(DEINT_MAX + SYNC_STAGES, ZERO_TIMEOUT));
    localparam int CNT_W   = $clog2(CNT_TOP + 1);

    logic             cmp_lvl, cmp_fall;
    phase_e           phase;
    logic             sign_load, sign_val, cap, cap_ovr;
    logic [MAG_W-1:0] cap_mag;
    res_flags_t       flags;

    dslope_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cmp_i  (cmp_i),
        .lvl_o  (cmp_lvl),
        .fall_o (cmp_fall)
    );

    dslope_phase_ctrl #(
        .AZ_CYCLES    (AZ_CYCLES),
        .INT_CYCLES   (INT_CYCLES),
        .DEINT_MAX    (DEINT_MAX),
        .ZERO_TIMEOUT (ZERO_TIMEOUT),
        .SYNC_STAGES  (SYNC_STAGES),
        .CNT_W        (CNT_W),
        .MAG_W        (MAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .continuous_i (continuous_i),
        .cmp_lvl_i    (cmp_lvl),
        .cmp_fall_i   (cmp_fall),
        .phase_o      (phase),
        .sign_load_o  (sign_load),
        .sign_val_o   (sign_val),
        .cap_o        (cap),
        .cap_mag_o    (cap_mag),
        .cap_ovr_o    (cap_ovr),
        .zero_err_o   (zero_err_o)
    );

    dslope_result #(.MAG_W(MAG_W), .DEINT_MAX(DEINT_MAX)) u_res (
        .clk         (clk),
        .rst         (rst),
        .sign_load_i (sign_load),
        .sign_val_i  (sign_val),
        .cap_i       (cap),
        .cap_mag_i   (cap_mag),
        .cap_ovr_i   (cap_ovr),
        .mag_o       (result_mag_o),
        .flags_o     (flags),
        .valid_o     (result_valid_o)
    );

    assign phase_ab_o    = phase;
    assign result_sign_o = flags.sign;
    assign result_ovr_o  = flags.ovr;
endmodule

// File: tb/test_dslope_seq.sv
`timescale 1ns/1ps
module test_dslope_seq;
    localparam int AZ   = 6;
    localparam int INTC = 10;
    localparam int DMAX = 30;
    localparam int ZTO  = 8;
    localparam int MW   = $clog2(DMAX + 1);

    logic          clk = 1'b0;
    logic          rst, start_i, continuous_i, cmp_i;
    logic [1:0]    phase_ab_o;
    logic [MW-1:0] result_mag_o;
    logic          result_sign_o, result_ovr_o, result_valid_o, zero_err_o;

    always #2.5 clk = ~clk;

    dslope_seq #(.AZ_CYCLES(AZ), .INT_CYCLES(INTC), .DEINT_MAX(DMAX),
                 .ZERO_TIMEOUT(ZTO), .SYNC_STAGES(2)) i_dslope_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .continuous_i(continuous_i),
        .cmp_i(cmp_i), .phase_ab_o(phase_ab_o), .result_mag_o(result_mag_o),
        .result_sign_o(result_sign_o), .result_ovr_o(result_ovr_o),
        .result_valid_o(result_valid_o), .zero_err_o(zero_err_o));

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 auto zero, 1 integrate, 2 deintegrate, 3 integrator zero
    int m_ph, m_cnt, m_mag;
    bit m_pend, m_sign_h, m_sign, m_ovr, m_valid, m_err;
    bit hist[$];   // sampled comparator, newest at front

    function automatic logic [1:0] ab_of(input int ph);
        case (ph)
            0: return 2'b01;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_mag = 0; m_pend = 0; m_sign_h = 0;
            m_sign = 0; m_ovr = 0; m_valid = 0; m_err = 0;
            hist = '{0, 0, 0};
        end else begin
            bit lvl, fall;
            lvl  = hist[1];
            fall = hist[2] && !hist[1];
            m_valid = 0;
            case (m_ph)
                0: if (m_cnt >= AZ - 1 && (m_pend || start_i || continuous_i)) begin
                       m_ph = 1; m_cnt = 0; m_pend = 0;
                   end else begin
                       if (m_cnt < AZ - 1) m_cnt++;
                       if (start_i) m_pend = 1;
                   end
                1: begin
                       if (start_i) m_pend = 1;
                       if (m_cnt == INTC - 1) begin
                           m_sign_h = !lvl; m_ph = 2; m_cnt = 0;
                       end else m_cnt++;
                   end
                2: begin
                       if (start_i) m_pend = 1;
                       if (fall) begin
                           m_mag = (m_cnt >= 2) ? m_cnt - 2 : 0; m_ovr = 0;
                           m_sign = m_sign_h; m_valid = 1; m_ph = 3; m_cnt = 0;
                       end else if (m_cnt == DMAX + 1) begin
                           m_mag = DMAX; m_ovr = 1;
                           m_sign = m_sign_h; m_valid = 1; m_ph = 3; m_cnt = 0;
                       end else m_cnt++;
                   end
                default: begin
                       if (start_i) m_pend = 1;
                       if (lvl) begin m_ph = 0; m_cnt = 0; end
                       else if (m_cnt == ZTO - 1) begin m_ph = 0; m_cnt = 0; m_err = 1; end
                       else m_cnt++;
                   end
            endcase
            hist.push_front(cmp_i);
            void'(hist.pop_back());
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            chk(phase_ab_o == ab_of(m_ph), "R2", "phase_ab", phase_ab_o, ab_of(m_ph));
            chk(result_valid_o == m_valid, "R10", "valid", result_valid_o, m_valid);
            chk(result_mag_o == m_mag, "R6", "magnitude", result_mag_o, m_mag);
            chk(result_sign_o == m_sign, "R5", "sign", result_sign_o, m_sign);
            chk(result_ovr_o == m_ovr, "R7", "over-range", result_ovr_o, m_ovr);
            chk(zero_err_o == m_err, "R9", "zero_err", zero_err_o, m_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_ab(input logic [1:0] v);
        @(negedge clk);
        while (phase_ab_o !== v) @(negedge clk);
    endtask

    // One conversion: j < 0 means the comparator never falls; iz < 0 means it
    // never returns high during integrator zero.
    task automatic run_conv(input bit kick, input bit queue, input bit neg,
                            input int j, input int iz, input int exp_mag,
                            input bit exp_ovr, input string tag,
                            output int iz_len);
        int t_valid;
        cmp_i = neg ? 1'b0 : 1'b1;
        repeat (2) @(posedge clk);
        #1;
        if (kick) begin
            start_i = 1; @(posedge clk); #1 start_i = 0;
        end
        wait_ab(2'b10);
        if (queue) begin
            @(posedge clk); #1 start_i = 1; @(posedge clk); #1 start_i = 0;
        end
        wait_ab(2'b11);
        if (neg) cmp_i = 1'b1;
        if (j >= 0) begin
            repeat (j) @(posedge clk);
            if (j > 0) #1;
            cmp_i = 1'b0;
        end
        @(negedge clk);
        while (!result_valid_o) @(negedge clk);
        t_valid = cyc;
        chk(result_mag_o == exp_mag, "R6", {tag, " magnitude"}, result_mag_o, exp_mag);
        chk(result_ovr_o == exp_ovr, "R7", {tag, " over-range"}, result_ovr_o, exp_ovr);
        chk(result_sign_o == neg, "R5", {tag, " sign"}, result_sign_o, neg);
        chk(phase_ab_o == 2'b00, "R10", {tag, " valid in first zero cycle"}, phase_ab_o, 0);
        if (iz >= 0) begin
            repeat (iz) @(posedge clk);
            #1 cmp_i = 1'b1;
        end
        wait_ab(2'b01);
        iz_len = cyc - t_valid;
    endtask

    task automatic az_len(output int n);
        n = 0;
        while (phase_ab_o !== 2'b10 && n < 100) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        int len;
        rst = 1; start_i = 0; continuous_i = 0; cmp_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(phase_ab_o == 2'b01, "R1", "reset phase", phase_ab_o, 1);
        chk(result_valid_o == 0 && zero_err_o == 0, "R1", "reset flags",
            result_valid_o + zero_err_o, 0);
        chk(result_mag_o == 0, "R1", "reset magnitude", result_mag_o, 0);
        @(posedge clk); #1 rst = 0;

        // R3 idle with toggling comparator: stays in auto zero
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1 cmp_i = ~cmp_i;
            @(negedge clk);
            chk(phase_ab_o == 2'b01, "R3", "idle holds auto zero", phase_ab_o, 1);
        end

        // R6 positive input, fall in cycle 12
        run_conv(1, 0, 0, 12, 3, 12, 0, "pos j12", len);
        // R5 negative input, fall in cycle 5
        run_conv(1, 0, 1, 5, 2, 5, 0, "neg j5", len);
        // R8 integrator zero ends two cycles after comparator high
        chk(len >= 2, "R8", "zero phase waits for comparator", len, 2);
        // R7 never falls: saturate
        run_conv(1, 0, 0, -1, 0, DMAX, 1, "overrange", len);
        chk(len == 1, "R8", "zero phase exits at once when high", len, 1);
        // R6 boundaries: earliest and latest valid fall
        run_conv(1, 0, 0, 0, 1, 0, 0, "pos j0", len);
        run_conv(1, 0, 0, DMAX - 1, 1, DMAX - 1, 0, "pos jmax", len);
        // R11 start pulse during integration is queued
        run_conv(1, 1, 0, 7, 1, 7, 0, "queued", len);
        az_len(len);
        chk(len == AZ, "R11", "queued start after full auto zero", len, AZ);
        chk(len >= AZ, "R3", "auto zero minimum length", len, AZ);
        run_conv(0, 0, 1, 9, 1, 9, 0, "from queue", len);
        // R9 integrator zero timeout
        chk(zero_err_o == 0, "R9", "no error before timeout", zero_err_o, 0);
        run_conv(1, 0, 0, 4, -1, 4, 0, "timeout", len);
        chk(len == ZTO, "R9", "timeout length", len, ZTO);
        chk(zero_err_o == 1, "R9", "error set", zero_err_o, 1);
        cmp_i = 1;
        // R11 continuous mode
        continuous_i = 1;
        run_conv(0, 0, 0, 3, 1, 3, 0, "cont1", len);
        az_len(len);
        chk(len == AZ, "R11", "continuous restart", len, AZ);
        continuous_i = 0;
        run_conv(0, 0, 1, 11, 1, 11, 0, "cont2", len);
        // R3 no restart without request
        for (int i = 0; i < 2 * AZ; i++) begin
            @(negedge clk);
            chk(phase_ab_o == 2'b01, "R3", "no restart", phase_ab_o, 1);
        end
        chk(zero_err_o == 1, "R9", "error sticky", zero_err_o, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule